// File: doc/BRIEF.md
# Enable-Pin Controller Register Slave

This block holds the configuration word and the interrupt-status word of an enable-pin controller. A simple single-cycle port reads and writes both words: a request is taken in the cycle where it is valid, a write updates state at the next clock edge, and read data appears combinationally in the same cycle. The mode, the debounce code and the press-timing codes drive the controller's timers directly through dedicated outputs.

The controller reports short-press and long-press events on set inputs. The block latches them into sticky flags, raises a level interrupt while any flag is set, and lets software clear each flag by writing one to its bit. The block emits a clear strobe toward the controller whenever a flag is cleared.

The pulse-reset mode cannot be left once it is entered. The block emits one arming pulse toward the pulse-reset logic when the mode is entered, and from then on it ignores mode writes. Only a forced system reset from the controller returns the whole configuration, including this lock, to its reset state.

Top module: `pinctl_regs`

## Requirements
- R1: The configuration word at offset 0x50 reads as: debounce code in bits 2:0, short-press code in 6:4, long-press code in 10:8, acknowledge code in 13:12, mode in 17:16, live pin level in bit 18. All other bits read as zero, and writes to those bits are ignored.
- R2: After reset the configuration word holds debounce code 3'b001 and zero in every other writable field, so the mode is 2'b00. Both status flags are zero and the interrupt is low.
- R3: Mode 2'b00 selects level reset and 2'b01 selects interrupt mode. A written mode is visible on `mode_o` from the cycle after the write. The field codes are also driven on their own outputs.
- R4: A write whose mode value has bit 1 set (2'b10 or 2'b11), made while the mode is not locked, raises `pulse_arm_o` for exactly one cycle, in the cycle after the write.
- R5: Once pulse mode is entered, later writes to the mode field are ignored, the mode reads and drives 2'b11, and no further arming pulse occurs. The other fields stay writable.
- R6: The status word at offset 0x54 holds the short-press flag in bit 0 and the long-press flag in bit 1. A set input makes its flag 1 until it is cleared. Writing 1 to a bit clears that flag and pulses the matching clear strobe during the write cycle. Writing 0 has no effect.
- R7: When a set input and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is high exactly when at least one status flag is set.
- R9: A one-cycle `force_rst_i` returns every configuration field, including the pulse-mode lock, to its reset value. After that, pulse mode can be entered again and arms again.
- R10: A read at any other offset returns zero, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| pin_level_i | input | 1 | Debounced enable-pin level |
| sp_set_i | input | 1 | Short-press event from controller |
| lp_set_i | input | 1 | Long-press event from controller |
| force_rst_i | input | 1 | Controller forced a system reset |
| mode_o | output | 2 | Current mode (2'b11 when locked) |
| dbc_code_o | output | 3 | Debounce time code |
| tsp_code_o | output | 3 | Short-press threshold code |
| tlp_code_o | output | 3 | Long-press threshold code |
| tack_code_o | output | 2 | Acknowledge window code |
| pulse_arm_o | output | 1 | One-cycle arming pulse on pulse-mode entry |
| sp_clr_o | output | 1 | Short-press flag cleared by software |
| lp_clr_o | output | 1 | Long-press flag cleared by software |
| irq_o | output | 1 | Level interrupt, OR of the flags |

## Verification
Two functions can meet in the same cycle: a controller set request and a software write-one-to-clear on the same status flag. The bench raises the short-press set input in the same cycle as a write of 1 to bit 0 of the status word. It then reads the status word back through the scoreboard and expects the flag to be set and the interrupt to be high. A clear made in a cycle with no set is checked on its own, so the two outcomes can be told apart.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
   localparam int DBC_W  = 3;
   localparam int TSP_W  = 3;
   localparam int TLP_W  = 3;
   localparam int TACK_W = 2;
   localparam int MODE_W = 2;

   // bit positions in the configuration word
   localparam int DBC_LSB  = 0;
   localparam int TSP_LSB  = 4;
   localparam int TLP_LSB  = 8;
   localparam int TACK_LSB = 12;
   localparam int MODE_LSB = 16;
   localparam int PIN_BIT  = 18;
   localparam int CFG_MSB  = PIN_BIT;

   localparam logic [MODE_W-1:0] MODE_LEVEL  = 2'b00;
   localparam logic [MODE_W-1:0] MODE_IRQ    = 2'b01;
   localparam logic [MODE_W-1:0] MODE_PULSED = 2'b11;

   typedef struct packed {
      logic [MODE_W-1:0] mode;
      logic [TACK_W-1:0] tack;
      logic [TLP_W-1:0]  tlp;
      logic [TSP_W-1:0]  tsp;
      logic [DBC_W-1:0]  dbc;
   } cfg_t;
endpackage

// File: rtl/pinctl_cfg_reg.sv
module pinctl_cfg_reg
   import pinctl_pkg::*;
#(
   parameter logic [DBC_W-1:0] DBC_RST = 3'b001
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  cfg_t wr_cfg,
   input  logic force_rst,
   output cfg_t cfg_o,
   output logic arm_o
);
   cfg_t cfg_q;
   logic lock_q;
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         cfg_q.dbc <= DBC_RST;
         lock_q    <= 1'b0;
         arm_q     <= 1'b0;
      end else if (force_rst) begin
         cfg_q     <= '0;
         cfg_q.dbc <= DBC_RST;
         lock_q    <= 1'b0;
         arm_q     <= 1'b0;
      end else begin
         arm_q <= 1'b0;
         if (wr_en) begin
            cfg_q.dbc  <= wr_cfg.dbc;
            cfg_q.tsp  <= wr_cfg.tsp;
            cfg_q.tlp  <= wr_cfg.tlp;
            cfg_q.tack <= wr_cfg.tack;
            if (!lock_q) begin
               cfg_q.mode <= wr_cfg.mode;
               if (wr_cfg.mode[1]) begin
                  lock_q <= 1'b1;
                  arm_q  <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      cfg_o = cfg_q;
      if (lock_q) cfg_o.mode = MODE_PULSED;
   end
   assign arm_o = arm_q;

   // R4: the arming pulse lasts a single cycle
   a_r4_arm_single: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q |=> !arm_q);
   // R5: a locked mode holds across any write unless a forced reset occurs
   a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_o.mode == MODE_PULSED && !force_rst) |=> cfg_o.mode == MODE_PULSED);
   // R9: a forced reset restores the reset configuration
   a_r9_force_restores: assert property (@(posedge clk) disable iff (!rst_n)
      force_rst |=> (cfg_o.mode == MODE_LEVEL && cfg_o.dbc == DBC_RST && !arm_q));
endmodule

// File: rtl/pinctl_flag_bank.sv
module pinctl_flag_bank #(
   parameter int NUM_FLAGS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic [NUM_FLAGS-1:0] clr_i,
   output logic [NUM_FLAGS-1:0] flag_o
);
   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q <= 1'b0;
         else if (set_i[g]) flag_q <= 1'b1;   // set has priority
         else if (clr_i[g]) flag_q <= 1'b0;
      end
      assign flag_o[g] = flag_q;

      // R6: a set request leaves the flag set
      a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> flag_q);
      // R7: a collision of set and clear resolves to set
      a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[g] && clr_i[g]) |=> flag_q);
      // R6: a clear without a set empties the flag
      a_r6_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !set_i[g]) |=> !flag_q);
   end
endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs
   import pinctl_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h50,
   parameter logic [ADDR_W-1:0] STAT_OFS = 8'h54,
   parameter logic [2:0]        DBC_RST  = 3'b001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              pin_level_i,
   input  logic              sp_set_i,
   input  logic              lp_set_i,
   input  logic              force_rst_i,
   output logic [1:0]        mode_o,
   output logic [2:0]        dbc_code_o,
   output logic [2:0]        tsp_code_o,
   output logic [2:0]        tlp_code_o,
   output logic [1:0]        tack_code_o,
   output logic              pulse_arm_o,
   output logic              sp_clr_o,
   output logic              lp_clr_o,
   output logic              irq_o
);
   localparam int NUM_FLAGS = 2;

   if (DATA_W <= CFG_MSB) begin : g_bad_width
      $error("pinctl_regs: DATA_W too small for the configuration word");
   end
   if (CFG_OFS == STAT_OFS) begin : g_bad_map
      $error("pinctl_regs: offsets must differ");
   end

   logic hit_cfg, hit_stat, wr_cfg, wr_stat;
   logic wdata_unused;
   assign hit_cfg  = req_valid && (req_addr == CFG_OFS);
   assign hit_stat = req_valid && (req_addr == STAT_OFS);
   assign wr_cfg   = hit_cfg  && req_write;
   assign wr_stat  = hit_stat && req_write;
   assign wdata_unused = ^req_wdata;

   cfg_t wcfg, cfg;
   always_comb begin
      wcfg.dbc  = req_wdata[DBC_LSB  +: DBC_W];
      wcfg.tsp  = req_wdata[TSP_LSB  +: TSP_W];
      wcfg.tlp  = req_wdata[TLP_LSB  +: TLP_W];
      wcfg.tack = req_wdata[TACK_LSB +: TACK_W];
      wcfg.mode = req_wdata[MODE_LSB +: MODE_W];
   end

   pinctl_cfg_reg #(.DBC_RST(DBC_RST)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_cfg),
      .wr_cfg    (wcfg),
      .force_rst (force_rst_i),
      .cfg_o     (cfg),
      .arm_o     (pulse_arm_o)
   );

   logic [NUM_FLAGS-1:0] set_v, clr_v, flags;
   assign set_v = {lp_set_i, sp_set_i};
   assign clr_v = wr_stat ? req_wdata[NUM_FLAGS-1:0] : '0;

   pinctl_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .flag_o (flags)
   );

   assign sp_clr_o    = clr_v[0];
   assign lp_clr_o    = clr_v[1];
   assign irq_o       = |flags;
   assign mode_o      = cfg.mode;
   assign dbc_code_o  = cfg.dbc;
   assign tsp_code_o  = cfg.tsp;
   assign tlp_code_o  = cfg.tlp;
   assign tack_code_o = cfg.tack;

   always_comb begin
      rsp_rdata = '0;
      if (hit_cfg && !req_write) begin
         rsp_rdata[DBC_LSB  +: DBC_W]  = cfg.dbc;
         rsp_rdata[TSP_LSB  +: TSP_W]  = cfg.tsp;
         rsp_rdata[TLP_LSB  +: TLP_W]  = cfg.tlp;
         rsp_rdata[TACK_LSB +: TACK_W] = cfg.tack;
         rsp_rdata[MODE_LSB +: MODE_W] = cfg.mode;
         rsp_rdata[PIN_BIT]            = pin_level_i;
      end else if (hit_stat && !req_write) begin
         rsp_rdata[NUM_FLAGS-1:0] = flags;
      end
   end

   // R8: interrupt follows the flag state across edges
   a_r8_irq_after_set: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_set_i || lp_set_i) |=> irq_o);
   // R10: a write elsewhere leaves the configuration unchanged
   a_r10_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !hit_cfg && !force_rst_i) |=> $stable({dbc_code_o, tsp_code_o, tlp_code_o, tack_code_o}));
endmodule

// File: tb/pinctl_regs_tb.sv
module pinctl_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        pin_level_i = 1'b1, sp_set_i = 1'b0, lp_set_i = 1'b0, force_rst_i = 1'b0;
   logic [1:0]  mode_o, tack_code_o;
   logic [2:0]  dbc_code_o, tsp_code_o, tlp_code_o;
   logic        pulse_arm_o, sp_clr_o, lp_clr_o, irq_o;

   int checks = 0, errors = 0, arm_count = 0;
   logic seen_sp_clr, seen_lp_clr;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   pinctl_regs u_dut (.*);

   always @(posedge clk) if (rst_n && pulse_arm_o) arm_count++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compare reads against the scoreboard
   always @(negedge clk) begin
      if (req_valid && !req_write) begin
         if (exp_q.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
   end

   task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
      @(posedge clk); #1;
      exp_q.push_back(exp); tag_q.push_back(req);
      req_valid = 1; req_write = 0; req_addr = a;
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, logic with_sp = 0);
      @(posedge clk); #1;
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; sp_set_i = with_sp;
      @(negedge clk);
      seen_sp_clr = sp_clr_o; seen_lp_clr = lp_clr_o;
      @(posedge clk); #1;
      req_valid = 0; req_write = 0; sp_set_i = 0;
   endtask

   task automatic pulse_in(int which);
      @(posedge clk); #1;
      if (which == 0) sp_set_i = 1; else if (which == 1) lp_set_i = 1; else force_rst_i = 1;
      @(posedge clk); #1;
      sp_set_i = 0; lp_set_i = 0; force_rst_i = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R2 reset state
      chk("R2 mode", mode_o, 0);
      chk("R2 dbc", dbc_code_o, 1);
      chk("R2 irq", irq_o, 0);
      rd(8'h50, 32'h0004_0001, "R2 cfg read");
      rd(8'h54, 32'h0, "R2 status read");
      // R1 layout, reserved bits ignored, R3 interrupt mode
      wr(8'h50, 32'hFFFD_FFFF);
      chk("R3 mode irq", mode_o, 1);
      chk("R3 tsp", tsp_code_o, 7);
      chk("R3 tlp", tlp_code_o, 7);
      chk("R3 tack", tack_code_o, 3);
      chk("R4 no arm", arm_count, 0);
      rd(8'h50, 32'h0005_3777, "R1 layout pin1");
      pin_level_i = 0;
      rd(8'h50, 32'h0001_3777, "R1 layout pin0");
      wr(8'h50, 32'h0000_0425);
      chk("R3 mode level", mode_o, 0);
      rd(8'h50, 32'h0000_0425, "R3 readback");
      // R10 unmapped offset
      rd(8'h58, 32'h0, "R10 read zero");
      wr(8'h58, 32'hFFFF_FFFF);
      rd(8'h50, 32'h0000_0425, "R10 write ignored");
      // R6 sticky flags and W1C, R8 irq
      pulse_in(0);
      rd(8'h54, 32'h1, "R6 short set");
      chk("R8 irq on", irq_o, 1);
      pulse_in(1);
      rd(8'h54, 32'h3, "R6 both set");
      wr(8'h54, 32'h0);
      chk("R6 zero no strobe", {seen_lp_clr, seen_sp_clr}, 0);
      rd(8'h54, 32'h3, "R6 write zero no effect");
      wr(8'h54, 32'h1);
      chk("R6 sp strobe", {seen_lp_clr, seen_sp_clr}, 2'b01);
      rd(8'h54, 32'h2, "R6 short cleared");
      chk("R8 irq still", irq_o, 1);
      wr(8'h54, 32'h2);
      chk("R6 lp strobe", {seen_lp_clr, seen_sp_clr}, 2'b10);
      rd(8'h54, 32'h0, "R6 long cleared");
      chk("R8 irq off", irq_o, 0);
      // R7 collision
      wr(8'h54, 32'h1, 1'b1);
      rd(8'h54, 32'h1, "R7 set wins");
      chk("R7 irq", irq_o, 1);
      wr(8'h54, 32'h1);
      rd(8'h54, 32'h0, "R7 later clear");
      // R4 enter pulse mode with 2'b10
      @(posedge clk); #1;
      req_valid = 1; req_write = 1; req_addr = 8'h50; req_wdata = 32'h0002_0001;
      @(posedge clk); #1;
      req_valid = 0; req_write = 0;
      chk("R4 arm high", pulse_arm_o, 1);
      @(posedge clk); #1;
      chk("R4 arm low", pulse_arm_o, 0);
      chk("R4 arm once", arm_count, 1);
      chk("R5 mode 11", mode_o, 3);
      rd(8'h50, 32'h0003_0001, "R5 readback 11");
      // R5 locked
      wr(8'h50, 32'h0000_0021);
      rd(8'h50, 32'h0003_0021, "R5 mode write ignored");
      wr(8'h50, 32'h0003_0021);
      chk("R5 no rearm", arm_count, 1);
      chk("R5 mode still 11", mode_o, 3);
      // R9 forced reset
      pulse_in(2);
      chk("R9 mode", mode_o, 0);
      rd(8'h50, 32'h0000_0001, "R9 cfg restored");
      wr(8'h50, 32'h0003_0001);
      @(posedge clk); #1;
      chk("R9 rearm", arm_count, 2);
      rd(8'h50, 32'h0003_0001, "R9 relocked");
      repeat (2) @(posedge clk);
      chk("scoreboard drained", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule